// File: doc/BRIEF.md
# Power-Fail Protected Byte SRAM

This block is a clocked model of a battery-backed static byte memory. Its controls are asynchronous and active low: select, read enable and write enable. Digital comparator flags report the state of the supply. All of these are sampled on the system clock. The block has three jobs:

- It decodes read cycles and write cycles from the control levels.
- It checks the timing rules that a real part imposes: recovery after a write, a stable address while a write is open, and release of the output drivers when a write interrupts a read.
- It keeps track of where the memory draws its power.

The tri-state data bus is split into a data output and an output-enable pin, which drives the pad buffer. The write window opens when the second of the two enables falls, whichever one that is. It closes at the first enable rise. The byte is stored when the window closes. A supervisor state machine stops all access while the supply is not good. It moves the array onto the battery when the rail collapses. A seal, set at reset, keeps the battery out of circuit until the supply has been good once.

The block is used where a host drives a memory-style control bus and the stored bytes must survive a loss of the main supply. The address width is a parameter. Thirteen bits gives the full 8192-byte array, and the default elaboration uses a smaller array.

Top module: `pfsram_top`

## Requirements
- R1: After reset, `sealed` is 1, `bat_sel` is 0 and `dout_oe` is 0. Every byte reads as 8'h00 until it is first written.
- R2: `dout_oe` is 1 and `dout` carries the stored byte at `addr` only while `ce_n`=0, `oe_n`=0 and `we_n`=1 and access is enabled. An input change reaches these outputs 3 clocks later.
- R3: A write window exists while both `ce_n` and `we_n` are 0. The falls and rises may come in any order. When the window closes, the byte at the latched address takes the `din` value sampled on the last clock on which the window was still open.
- R4: With `ce_n`=`oe_n`=0, a fall of `we_n` leaves `dout_oe` at 1 for ODW_CYC further clocks and then clears it.
- R5: After a write window closes, `we_n` must stay high for REC_CYC synchronized clocks. A read or write that starts sooner is ignored: no byte changes and the outputs are not driven. Such a start pulses `proto_err` for one clock.
- R6: If `addr` changes while a write window is open, that write is dropped and `addr_err` pulses once. Neither the old address nor the new one is modified.
- R7: While `pwr_good`=0, no byte is written and the control inputs cause no errors. `dout_oe` falls within 4 clocks of the `pwr_good` drop.
- R8: Once the block is unsealed, `bat_sel` is 1 exactly while `pwr_low`=1, with a latency of 3 clocks. When `pwr_low` clears, access resumes only after `pwr_good` is 1.
- R9: While sealed, `bat_sel` stays 0 whatever `pwr_low` does. The seal clears when `pwr_good`=1 and `pwr_low`=0 are first seen, and it never returns before the next reset.
- R10: Stored bytes are unchanged after a spell of write protection or battery operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples every input |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, valid while dout_oe is 1 |
| dout_oe | output | 1 | Drive enable for the external tri-state buffer |
| pwr_good | input | 1 | Supply is above the full-function threshold |
| pwr_low | input | 1 | Supply is below the battery switch-over level |
| bat_sel | output | 1 | 1 selects the battery for the array, 0 the main supply |
| sealed | output | 1 | The battery is still held disconnected |
| proto_err | output | 1 | One-clock pulse when a cycle starts inside the recovery time |
| addr_err | output | 1 | One-clock pulse when the address moves during a write |

## Verification
Faults in the write-window tracking show up in storage. A window latched at the wrong address, or committed with stale data, or committed when it should have been dropped, all leave a wrong byte behind. That byte becomes visible on `dout` at the next read, three clocks after the read select settles. The bench therefore sweeps every address and reads it back after each write phase and after each power excursion. A wrong supervisor state is visible sooner and needs no read: `bat_sel` or `sealed` holds the wrong level three clocks after the flag change. An enable that was not cut off by the state machine keeps `dout_oe` high past the fourth clock after `pwr_good` falls. Mistakes in the recovery counter and the output-release counter show as an error pulse, or a missing one, within a few clocks. They also show as a driven bus one clock away from the expected boundary.

// File: rtl/pfsram_pkg.sv
package pfsram_pkg;

  // Supervisor states for the array supply.
  typedef enum logic [1:0] {
    PS_SEALED = 2'd0,  // battery never connected yet
    PS_ON     = 2'd1,  // full function
    PS_PROT   = 2'd2,  // write protected, on main rail
    PS_BATT   = 2'd3   // array held by battery
  } pwr_st_t;

  // Idle levels of the active-low controls after reset.
  localparam logic [2:0] CTL_IDLE = 3'b111;
  // Idle levels of {good, low}: no supply.
  localparam logic [1:0] PWR_IDLE = 2'b01;

endpackage

// File: rtl/pfsram_sync.sv
module pfsram_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{INIT}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pfsram_pwr.sv
module pfsram_pwr
  import pfsram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic good_s,
  input  logic low_s,
  output logic acc_en,
  output logic bat_sel,
  output logic sealed
);

  pwr_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_SEALED: if (good_s && !low_s) st_d = PS_ON;
      default: begin
        if (low_s)       st_d = PS_BATT;
        else if (good_s) st_d = PS_ON;
        else             st_d = PS_PROT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_SEALED;
    else        st_q <= st_d;
  end

  assign acc_en  = (st_q == PS_ON);
  assign bat_sel = (st_q == PS_BATT);
  assign sealed  = (st_q == PS_SEALED);

endmodule

// File: rtl/pfsram_cycle.sv
module pfsram_cycle #(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int REC_CYC = 4,
  parameter int ODW_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_drive,
  output logic              proto_err,
  output logic              addr_err
);

  localparam int RW = $clog2(REC_CYC + 1);
  localparam int OW = $clog2(ODW_CYC + 2);
  localparam logic [RW-1:0] REC_LOAD = RW'(REC_CYC - 1);
  localparam logic [OW-1:0] ODW_MAX  = OW'(ODW_CYC);

  logic          win_q, rd_q, w_bad, w_abrt, rd_blk;
  logic [RW-1:0] rec_q;
  logic [OW-1:0] odw_q;

  logic win_now, rd_now, opening, closing, rd_start, busy, blk_now;

  assign win_now  = en && !ce_n && !we_n;
  assign rd_now   = en && !ce_n && !oe_n && we_n;
  assign opening  = win_now && !win_q;
  assign closing  = win_q && !win_now;
  assign rd_start = rd_now && !rd_q;
  assign busy     = (rec_q != '0);
  assign blk_now  = rd_blk || (rd_start && busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q     <= 1'b0;
      rd_q      <= 1'b0;
      w_bad     <= 1'b0;
      w_abrt    <= 1'b0;
      rd_blk    <= 1'b0;
      rec_q     <= '0;
      odw_q     <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
      proto_err <= 1'b0;
      addr_err  <= 1'b0;
    end else begin
      win_q     <= win_now;
      rd_q      <= rd_now;
      proto_err <= (opening || rd_start) && busy;
      addr_err  <= 1'b0;

      // Window bookkeeping: latch address at open, watch it afterwards.
      if (opening) begin
        wr_addr <= addr;
        w_bad   <= busy;
        w_abrt  <= 1'b0;
      end else if (win_q && win_now && (addr != wr_addr) && !w_abrt) begin
        w_abrt   <= 1'b1;
        addr_err <= 1'b1;
      end

      // Data follows din while the window is open; last sample wins.
      if (win_now) wr_data <= din;

      // Recovery counter after every window close.
      if (!en)          rec_q <= '0;
      else if (closing) rec_q <= REC_LOAD;
      else if (busy)    rec_q <= rec_q - 1'b1;

      // Read blocking lasts for the whole select period.
      if (!en || ce_n || oe_n) rd_blk <= 1'b0;
      else if (rd_start)       rd_blk <= busy;

      // Clocks since write enable fell.
      if (we_n)                  odw_q <= '0;
      else if (odw_q != ODW_MAX) odw_q <= odw_q + 1'b1;
    end
  end

  assign wr_en    = closing && en && !w_bad && !w_abrt;
  assign rd_drive = en && !ce_n && !oe_n && !blk_now && (we_n || (odw_q < ODW_MAX));

endmodule

// File: rtl/pfsram_store.sv
module pfsram_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DEPTH-1:0]  written;

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     written <= '0;
    else if (wr_en) written[wr_addr] <= 1'b1;
  end

  assign rd_data = written[rd_addr] ? cells[rd_addr] : '0;

endmodule

// File: rtl/pfsram_top.sv
module pfsram_top
  import pfsram_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int DATA_W  = 8,
  parameter int REC_CYC = 4,
  parameter int ODW_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  input  logic              pwr_good,
  input  logic              pwr_low,
  output logic              bat_sel,
  output logic              sealed,
  output logic              proto_err,
  output logic              addr_err
);

  localparam int BUS_W = ADDR_W + DATA_W;

  logic ce_s, oe_s, we_s, good_s, low_s, acc_en;
  logic [ADDR_W-1:0] addr_s, wr_addr;
  logic [DATA_W-1:0] din_s, wr_data, rd_data;
  logic wr_en, rd_drive;

  pfsram_sync #(.W(3), .STAGES(2), .INIT(CTL_IDLE)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d({ce_n, oe_n, we_n}), .q({ce_s, oe_s, we_s})
  );

  pfsram_sync #(.W(BUS_W), .STAGES(2), .INIT('0)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d({addr, din}), .q({addr_s, din_s})
  );

  pfsram_sync #(.W(2), .STAGES(2), .INIT(PWR_IDLE)) u_sync_pwr (
    .clk(clk), .rst_n(rst_n), .d({pwr_good, pwr_low}), .q({good_s, low_s})
  );

  pfsram_pwr u_pwr (
    .clk(clk), .rst_n(rst_n), .good_s(good_s), .low_s(low_s),
    .acc_en(acc_en), .bat_sel(bat_sel), .sealed(sealed)
  );

  pfsram_cycle #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REC_CYC(REC_CYC), .ODW_CYC(ODW_CYC)
  ) u_cycle (
    .clk(clk), .rst_n(rst_n), .en(acc_en),
    .ce_n(ce_s), .oe_n(oe_s), .we_n(we_s), .addr(addr_s), .din(din_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_drive(rd_drive), .proto_err(proto_err), .addr_err(addr_err)
  );

  pfsram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(addr_s), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= rd_drive;
      dout    <= rd_drive ? rd_data : '0;
    end
  end

endmodule

// File: rtl/pfsram_chk.sv
module pfsram_chk (
  input logic clk,
  input logic rst_n,
  input logic acc_en,
  input logic dout_oe,
  input logic bat_sel,
  input logic sealed,
  input logic wr_en,
  input logic proto_err,
  input logic addr_err,
  input logic ce_s,
  input logic oe_s,
  input logic low_s
);

  // R7
  float_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !dout_oe);

  // R2
  drive_needs_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> $past(!ce_s && !oe_s));

  // R8
  battery_follows_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sel |-> $past(low_s));

  // R9
  seal_one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sealed |=> !sealed);

  // R7
  commit_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> acc_en);

  // R6
  single_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({proto_err, addr_err}));

endmodule

bind pfsram_top pfsram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .dout_oe(dout_oe),
  .bat_sel(bat_sel), .sealed(sealed), .wr_en(wr_en), .proto_err(proto_err),
  .addr_err(addr_err), .ce_s(ce_s), .oe_s(oe_s), .low_s(low_s)
);

// File: tb/pfsram_top_test.sv
module pfsram_top_test;

  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int REC   = 3;
  localparam int ODW   = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_oe, bat_sel, sealed, proto_err, addr_err;
  logic pwr_good = 1'b0, pwr_low = 1'b1;

  int vectors = 0;
  int fails = 0;
  int pe_cnt = 0;
  int ae_cnt = 0;
  logic [DW-1:0] model [DEPTH];

  always #10 clk = ~clk;

  pfsram_top #(.ADDR_W(AW), .DATA_W(DW), .REC_CYC(REC), .ODW_CYC(ODW)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .pwr_good(pwr_good), .pwr_low(pwr_low), .bat_sel(bat_sel),
    .sealed(sealed), .proto_err(proto_err), .addr_err(addr_err)
  );

  always @(posedge clk) begin
    if (proto_err) pe_cnt++;
    if (addr_err)  ae_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * k + 7 * k + 3) & 8'hFF);
  endfunction

  // Plain write, ce and we fall together, hold 3 clocks, then a safe gap.
  task automatic wr(input int a, input logic [DW-1:0] d);
    addr = AW'(a); din = d; ce_n = 0; oe_n = 1; we_n = 0;
    cyc(3);
    ce_n = 1; we_n = 1;
    cyc(6);
  endtask

  task automatic rd_check(input int a, input string req);
    addr = AW'(a); ce_n = 0; oe_n = 0; we_n = 1;
    cyc(4);
    check(dout_oe === 1'b1, req, dout_oe, 1);
    check(dout === model[a], req, dout, model[a]);
    ce_n = 1; oe_n = 1;
    cyc(4);
    check(dout_oe === 1'b0, req, dout_oe, 0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int pe0, ae0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    cyc(3);
    rst_n = 1;
    cyc(2);
    // R1 reset state
    check(sealed === 1'b1, "R1", sealed, 1);
    check(bat_sel === 1'b0, "R1", bat_sel, 0);
    check(dout_oe === 1'b0, "R1", dout_oe, 0);
    // R9 low flag ignored while sealed
    cyc(5);
    check(bat_sel === 1'b0, "R9", bat_sel, 0);
    // R7 no access before power good
    addr = 0; ce_n = 0; oe_n = 0;
    cyc(5);
    check(dout_oe === 1'b0, "R7", dout_oe, 0);
    ce_n = 1; oe_n = 1;
    // power up: seal clears
    pwr_low = 0; pwr_good = 1;
    cyc(5);
    check(sealed === 1'b0, "R9", sealed, 0);
    check(bat_sel === 1'b0, "R9", bat_sel, 0);

    // R1 every byte reads zero before any write
    for (int a = 0; a < DEPTH; a++) rd_check(a, "R1");

    // R2 R3 sweep two patterns
    for (int k = 1; k <= 2; k++) begin
      for (int a = 0; a < DEPTH; a++) begin
        model[a] = pat(a, 29 * k + 1);
        wr(a, model[a]);
      end
      for (int a = 0; a < DEPTH; a++) rd_check(a, "R2");
    end

    // R2 oe high: no drive
    addr = 2; ce_n = 0; oe_n = 1; we_n = 1;
    cyc(5);
    check(dout_oe === 1'b0, "R2", dout_oe, 0);
    ce_n = 1;
    cyc(5);

    // R3 we falls first, ce later, ce rises first; data changes mid-window
    addr = 5; din = 8'h11; we_n = 0;
    cyc(2);
    ce_n = 0;
    cyc(2);
    din = 8'hA7;
    cyc(2);
    ce_n = 1;
    cyc(1);
    we_n = 1; din = 8'h00;
    cyc(6);
    model[5] = 8'hA7;
    rd_check(5, "R3");
    // R3 ce falls first, we later, we rises first
    addr = 9; din = 8'h3C; ce_n = 0;
    cyc(2);
    we_n = 0;
    cyc(3);
    din = 8'h5E;
    cyc(1);
    we_n = 1;
    cyc(1);
    ce_n = 1; din = 8'hFF;
    cyc(6);
    model[9] = 8'h5E;
    rd_check(9, "R3");

    // R4 output release after we falls during a read
    addr = 3; ce_n = 0; oe_n = 0; we_n = 1;
    cyc(5);
    check(dout_oe === 1'b1, "R4", dout_oe, 1);
    din = 8'hC3; we_n = 0;
    cyc(2 + ODW);
    check(dout_oe === 1'b1, "R4", dout_oe, 1);
    cyc(1);
    check(dout_oe === 1'b0, "R4", dout_oe, 0);
    ce_n = 1; oe_n = 1; we_n = 1;
    cyc(6);
    model[3] = 8'hC3;
    rd_check(3, "R4");

    // R5 write started too early is ignored
    pe0 = pe_cnt;
    addr = 1; din = 8'h4D; ce_n = 0; we_n = 0;
    cyc(3);
    ce_n = 1; we_n = 1;
    cyc(REC - 1);
    din = 8'hB2; ce_n = 0; we_n = 0;
    cyc(3);
    ce_n = 1; we_n = 1;
    cyc(6);
    model[1] = 8'h4D;
    check(pe_cnt - pe0 == 1, "R5", pe_cnt - pe0, 1);
    rd_check(1, "R5");
    // R5 write after exactly the recovery time is accepted
    pe0 = pe_cnt;
    addr = 1; din = 8'h66; ce_n = 0; we_n = 0;
    cyc(3);
    ce_n = 1; we_n = 1;
    cyc(REC);
    din = 8'h99; ce_n = 0; we_n = 0;
    cyc(3);
    ce_n = 1; we_n = 1;
    cyc(6);
    model[1] = 8'h99;
    check(pe_cnt == pe0, "R5", pe_cnt - pe0, 0);
    rd_check(1, "R5");
    // R5 read started inside recovery is not driven
    pe0 = pe_cnt;
    addr = 4; din = 8'h21; ce_n = 0; we_n = 0;
    cyc(3);
    ce_n = 1; we_n = 1;
    cyc(1);
    ce_n = 0; oe_n = 0;
    cyc(5);
    check(dout_oe === 1'b0, "R5", dout_oe, 0);
    ce_n = 1; oe_n = 1;
    cyc(6);
    model[4] = 8'h21;
    check(pe_cnt - pe0 == 1, "R5", pe_cnt - pe0, 1);
    rd_check(4, "R5");

    // R6 address moves during a write
    ae0 = ae_cnt;
    addr = 6; din = 8'hE1; ce_n = 0; we_n = 0;
    cyc(3);
    addr = 7;
    cyc(3);
    ce_n = 1; we_n = 1;
    cyc(6);
    check(ae_cnt - ae0 == 1, "R6", ae_cnt - ae0, 1);
    rd_check(6, "R6");
    rd_check(7, "R6");

    // R7 supply loss cuts a read and blocks writes
    addr = 2; ce_n = 0; oe_n = 0; we_n = 1;
    cyc(5);
    check(dout_oe === 1'b1, "R7", dout_oe, 1);
    pwr_good = 0;
    cyc(3);
    check(dout_oe === 1'b1, "R7", dout_oe, 1);
    cyc(1);
    check(dout_oe === 1'b0, "R7", dout_oe, 0);
    ce_n = 1; oe_n = 1;
    cyc(2);
    pe0 = pe_cnt; ae0 = ae_cnt;
    addr = 2; din = 8'h5A; ce_n = 0; we_n = 0;
    cyc(1);
    addr = 8;
    cyc(3);
    ce_n = 1; we_n = 1;
    cyc(1);
    ce_n = 0; we_n = 0;
    cyc(3);
    ce_n = 1; we_n = 1;
    cyc(4);
    check(pe_cnt == pe0 && ae_cnt == ae0, "R7", pe_cnt + ae_cnt, pe0 + ae0);
    check(sealed === 1'b0, "R9", sealed, 0);

    // R8 battery switch-over and access resume rule
    pwr_low = 1;
    cyc(2);
    check(bat_sel === 1'b0, "R8", bat_sel, 0);
    cyc(1);
    check(bat_sel === 1'b1, "R8", bat_sel, 1);
    cyc(10);
    pwr_low = 0;
    cyc(3);
    check(bat_sel === 1'b0, "R8", bat_sel, 0);
    addr = 2; ce_n = 0; oe_n = 0;
    cyc(5);
    check(dout_oe === 1'b0, "R8", dout_oe, 0);
    ce_n = 1; oe_n = 1;
    pwr_good = 1;
    cyc(6);
    check(sealed === 1'b0, "R9", sealed, 0);

    // R10 contents kept through protection and battery spell
    for (int a = 0; a < DEPTH; a++) rd_check(a, "R10");

    finish_run();
  end

endmodule